// File: doc/BRIEF.md
# Battery Reversal and Ring Discriminator

This block watches the two threshold detectors that sense line voltage swings in the positive and negative directions. A swing past either threshold can mean one of two things. It may be a single reversal of the line battery polarity, which often comes just before caller identity data. It may also be the first half-cycle of a ringing burst. A single edge cannot tell these apart, so the block opens a qualification window when it sees the first edge. The window is counted in millisecond ticks and is longer than half the period of the slowest legal ring. If any further edge arrives before the window closes, the event is a ring. If the line stays quiet for the whole window, the event is a polarity reversal.

The detector inputs are asynchronous. Each one passes through its own synchronizer, and only rising edges of the synchronized signals count as events. A confirmed reversal produces a one-cycle pulse. It also raises a level that requests the reset of the ring-input coupling network. That level stays high until the host reports that the caller data has been received. A ring produces a one-cycle pulse, and then the block ignores the detectors until they have stayed quiet for a full window. The block is busy whenever it is not idle.

Top module: `polrev_discriminator`

## Requirements
- R1: After reset, `reversal_o`, `ring_o`, `busy_o` and `cid_prep_o` are all 0.
- R2: In the idle state, a rising edge of the synchronized positive detector opens a window, and `busy_o` goes to 1. A rising edge of the synchronized negative detector does the same when `fullwave_en_i` is 1.
- R3: If no further edge is seen while `WINDOW_MS` ticks are counted after the window opens, `reversal_o` pulses for one cycle and `busy_o` returns to 0. A tick that arrives in the same cycle as the opening edge is not counted.
- R4: An edge that arrives while the window is open makes `ring_o` pulse for one cycle, and no reversal is reported. This holds even when the edge comes in the same cycle as the final tick of the window.
- R5: After a ring, `busy_o` stays 1 and edges produce no pulses until `WINDOW_MS` ticks pass with no edge. Any edge in that time restarts the quiet count. After a full quiet window the block returns to idle.
- R6: While `fullwave_en_i` is 0, edges of the negative detector are ignored in every state.
- R7: `cid_prep_o` is set in the same cycle as `reversal_o`. It stays 1 until a cycle in which `cid_done_i` is 1, after which it is 0. If a set and a clear happen in the same cycle, the set wins.
- R8: `reversal_o` and `ring_o` are never 1 in the same cycle, and each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| det_pos_i | input | 1 | Raw positive-threshold detector, asynchronous |
| det_neg_i | input | 1 | Raw negative-threshold detector, asynchronous |
| fullwave_en_i | input | 1 | 1 lets the negative detector report events |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| cid_done_i | input | 1 | Caller data received; clears `cid_prep_o` |
| reversal_o | output | 1 | One-cycle pulse: battery reversal confirmed |
| ring_o | output | 1 | One-cycle pulse: ring detected |
| busy_o | output | 1 | A window is open, or the block is waiting for quiet after a ring |
| cid_prep_o | output | 1 | Coupling-network reset request for caller data capture |

## Verification
The assertions check on every cycle that the two pulses never coincide and last one cycle. They also check that a reversal raises the capture request and leaves the block idle, that a ring leaves it busy, and that the capture request only drops after a done indication. Only the bench scenarios can show the timing of the classification. These scenarios sweep the gap between two edges across the window boundary for every pairing of detectors. They also cover an edge that collides with the final tick, the restart of the quiet period after a ring, and the masking of the negative detector.

// File: rtl/pr_pkg.sv
package pr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_QUAL = 2'd1,
        ST_HOLD = 2'd2
    } pr_state_e;

    typedef struct packed {
        pr_state_e state;
        logic      rev;
        logic      ring;
        logic      prep;
    } pr_regs_t;

endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = din;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/pr_rise.sv
module pr_rise #(
    parameter int WIDTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sig,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb begin
        prev_d = sig;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            assign rise[b] = sig[b] & ~prev_q[b];
        end
    endgenerate

endmodule

// File: rtl/pr_window.sv
module pr_window #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);

    localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        expire = tick && !clr && (cnt_q == LAST);
        cnt_d  = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick) begin
            cnt_d = expire ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/polrev_discriminator.sv
module polrev_discriminator
    import pr_pkg::*;
#(
    parameter int WINDOW_MS   = 40,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic det_pos_i,
    input  logic det_neg_i,
    input  logic fullwave_en_i,
    input  logic ms_tick_i,
    input  logic cid_done_i,
    output logic reversal_o,
    output logic ring_o,
    output logic busy_o,
    output logic cid_prep_o
);

    localparam int NDET = 2;

    logic [NDET-1:0] det_sync, det_rise;
    logic            ev;
    logic            win_clr;
    logic            win_expire;
    pr_regs_t        r_d, r_q;

    pr_sync #(.WIDTH(NDET), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({det_neg_i, det_pos_i}),
        .dout  (det_sync)
    );

    pr_rise #(.WIDTH(NDET)) i_rise (
        .clk   (clk),
        .rst_n (rst_n),
        .sig   (det_sync),
        .rise  (det_rise)
    );

    pr_window #(.LIMIT(WINDOW_MS)) i_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (win_clr),
        .tick   (ms_tick_i),
        .expire (win_expire)
    );

    // Event: positive edge always, negative edge only with full-wave sensing (R2, R6)
    assign ev      = det_rise[0] | (fullwave_en_i & det_rise[1]);
    // Counter is held at zero while idle and restarts on every event
    assign win_clr = (r_q.state == ST_IDLE) | ev;

    always_comb begin
        r_d      = r_q;
        r_d.rev  = 1'b0;
        r_d.ring = 1'b0;
        if (cid_done_i) begin
            r_d.prep = 1'b0;
        end
        unique case (r_q.state)
            ST_IDLE: begin
                if (ev) begin
                    r_d.state = ST_QUAL;
                end
            end
            ST_QUAL: begin
                if (ev) begin
                    r_d.ring  = 1'b1;
                    r_d.state = ST_HOLD;
                end else if (win_expire) begin
                    r_d.rev   = 1'b1;
                    r_d.prep  = 1'b1;
                    r_d.state = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!ev && win_expire) begin
                    r_d.state = ST_IDLE;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, rev: 1'b0, ring: 1'b0, prep: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign reversal_o = r_q.rev;
    assign ring_o     = r_q.ring;
    assign busy_o     = (r_q.state != ST_IDLE);
    assign cid_prep_o = r_q.prep;

endmodule

// File: rtl/pr_checker.sv
module pr_checker (
    input logic clk,
    input logic rst_n,
    input logic cid_done_i,
    input logic reversal_o,
    input logic ring_o,
    input logic busy_o,
    input logic cid_prep_o
);

    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(reversal_o && ring_o));

    a_r8_rev_single: assert property (@(posedge clk) disable iff (!rst_n)
        reversal_o |=> !reversal_o);

    a_r8_ring_single: assert property (@(posedge clk) disable iff (!rst_n)
        ring_o |=> !ring_o);

    a_r7_prep_on_rev: assert property (@(posedge clk) disable iff (!rst_n)
        reversal_o |-> cid_prep_o);

    a_r7_prep_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cid_prep_o) |-> $past(cid_done_i));

    a_r3_idle_after_rev: assert property (@(posedge clk) disable iff (!rst_n)
        reversal_o |-> !busy_o);

    a_r5_busy_after_ring: assert property (@(posedge clk) disable iff (!rst_n)
        ring_o |-> busy_o);

endmodule

bind polrev_discriminator pr_checker i_pr_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cid_done_i (cid_done_i),
    .reversal_o (reversal_o),
    .ring_o     (ring_o),
    .busy_o     (busy_o),
    .cid_prep_o (cid_prep_o)
);

// File: tb/test_polrev_discriminator.sv
module test_polrev_discriminator;

    localparam int W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic det_pos = 1'b0, det_neg = 1'b0, fullwave = 1'b1, tick = 1'b0, cid_done = 1'b0;
    logic rev_o, ring_o, busy_o, prep_o;

    int checks = 0, errors = 0;
    int rev_cnt = 0, ring_cnt = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    polrev_discriminator #(.WINDOW_MS(W), .SYNC_STAGES(2)) i_polrev_discriminator (
        .clk           (clk),
        .rst_n         (rst_n),
        .det_pos_i     (det_pos),
        .det_neg_i     (det_neg),
        .fullwave_en_i (fullwave),
        .ms_tick_i     (tick),
        .cid_done_i    (cid_done),
        .reversal_o    (rev_o),
        .ring_o        (ring_o),
        .busy_o        (busy_o),
        .cid_prep_o    (prep_o)
    );

    always @(negedge clk) begin
        if (rev_o)  rev_cnt++;
        if (ring_o) ring_cnt++;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse(input bit neg);
        if (neg) det_neg = 1'b1; else det_pos = 1'b1;
        repeat (2) @(negedge clk);
        det_neg = 1'b0;
        det_pos = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic done_pulse();
        cid_done = 1'b1;
        @(negedge clk);
        cid_done = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=0", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int r0, g0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reversal", rev_o, 0);
        check("R1 ring", ring_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 prep", prep_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Sweep: gap in ticks between two edges, all detector pairings (R2, R3, R4, R5, R7)
        for (int fa = 0; fa < 2; fa++) begin
            for (int fb = 0; fb < 2; fb++) begin
                for (int g = 0; g <= W + 2; g++) begin
                    r0 = rev_cnt;
                    g0 = ring_cnt;
                    pulse(fa[0]);
                    check("R2 busy after first edge", busy_o, 1);
                    ticks(g);
                    check("R3 busy after gap", busy_o, (g >= W) ? 0 : 1);
                    check("R3 reversal after gap", rev_cnt - r0, (g >= W) ? 1 : 0);
                    pulse(fb[0]);
                    check("R4 ring count", ring_cnt - g0, (g < W) ? 1 : 0);
                    ticks(W);
                    check("R5 idle after quiet", busy_o, 0);
                    check("R3 total reversals", rev_cnt - r0, (g >= W) ? 2 : 0);
                    check("R7 prep level", prep_o, (g >= W) ? 1 : 0);
                    done_pulse();
                    check("R7 prep cleared", prep_o, 0);
                end
            end
        end

        // R3: tick in the same cycle as the opening edge is not counted
        r0 = rev_cnt;
        det_pos = 1'b1;
        repeat (2) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        det_pos = 1'b0;
        @(negedge clk);
        ticks(W - 1);
        check("R3 entry tick ignored", busy_o, 1);
        ticks(1);
        check("R3 reversal after full window", rev_cnt - r0, 1);
        done_pulse();

        // R4: edge coinciding with the final tick is a ring
        r0 = rev_cnt;
        g0 = ring_cnt;
        pulse(1'b0);
        ticks(W - 1);
        det_neg = 1'b1;
        repeat (2) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        det_neg = 1'b0;
        repeat (2) @(negedge clk);
        check("R4 collision ring", ring_cnt - g0, 1);
        check("R4 collision no reversal", rev_cnt - r0, 0);
        ticks(W);
        check("R4 idle after collision", busy_o, 0);

        // R5: an edge during the quiet period restarts it
        g0 = ring_cnt;
        r0 = rev_cnt;
        pulse(1'b0);
        pulse(1'b1);
        ticks(W - 1);
        pulse(1'b0);
        ticks(W - 1);
        check("R5 still busy after restart", busy_o, 1);
        check("R5 edges ignored in hold", ring_cnt - g0, 1);
        ticks(1);
        check("R5 idle after restart window", busy_o, 0);
        check("R5 no reversal from hold", rev_cnt - r0, 0);

        // R6: negative detector masked without full-wave sensing
        fullwave = 1'b0;
        r0 = rev_cnt;
        g0 = ring_cnt;
        pulse(1'b1);
        check("R6 neg edge ignored in idle", busy_o, 0);
        pulse(1'b0);
        pulse(1'b1);
        check("R6 neg edge no ring", ring_cnt - g0, 0);
        ticks(W);
        check("R6 reversal despite neg edge", rev_cnt - r0, 1);
        fullwave = 1'b1;

        // R7: set wins over a simultaneous clear
        done_pulse();
        pulse(1'b0);
        ticks(W - 1);
        tick = 1'b1;
        cid_done = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        cid_done = 1'b0;
        @(negedge clk);
        check("R7 set wins over clear", prep_o, 1);
        done_pulse();
        check("R7 clear", prep_o, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule